// File: doc/BRIEF.md
# Ping-Pong DMA Channel

One channel of a word-moving DMA engine. It copies 32-bit words between a peripheral-side port and a memory-side port. Software configures it through six registers: a control word, a status word, and one pointer and one sequence word for each side. In single-shot mode the channel moves one block and then stops. In continuous mode the programmed count covers half of a ping-pong buffer. The channel flags each half as it completes and keeps running until software disables it.

Each word is moved in two steps. First a read request goes to the source port. When that port accepts it, a write request carries the captured word to the destination port. Both ports use valid/ready. Once a request is raised, valid, write, address and write data stay fixed until ready is seen high on a clock edge. The only exception is disabling the channel, which withdraws the request. A responder may hold ready low for any number of cycles. Read data must be valid in the cycle in which the responder signals ready. Request lines and the global enable are plain level inputs.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset the status register (cfg_addr 1) reads 0, both port valids are low and irq is low.
- R2: Writing the control register (cfg_addr 0) with bit31 set while idle starts a block of N+1 words, where N is control bits 15:2. The mode is single-shot when control bit27 is set or memory sequence bit19 is clear. At the end of a single-shot block, busy (status bit31) and control bit31 both clear.
- R3: Control bit28 clear reads each word from the peripheral port and writes it to the memory port. Bit28 set reads from memory and writes to the peripheral.
- R4: Each side's address starts at its pointer register (memory cfg_addr 2, peripheral cfg_addr 4) with the low two bits forced to 0, and advances by 4 per word.
- R5: Bits 18:16 of a sequence word (memory cfg_addr 3, peripheral cfg_addr 5) select the address wrap. Code 0 is linear. A peripheral code k selects a window of 2^(k-1) words, and a memory code k selects 2^(k+4) words. After the last word of a window, the address returns to the start of that window.
- R6: When control bit30 is set, the end of every block sets pending (status bit30). Output irq mirrors pending. Writing the status register with bit30 set clears pending, and a new block end in the same cycle wins over the clear.
- R7: In continuous mode (bit27 clear, memory sequence bit19 set) the block is one half of the buffer. At every half the channel sets pending, toggles status bit28 (which starts at 0), reloads the count and carries on.
- R8: In continuous mode, a pointer rewritten during a run takes effect only when the second half ends and the buffer restarts.
- R9: With control bit21 set, a word starts only while the request line selected by control bits 20:16 is high. Other request lines have no effect. With bit21 clear, words start freely.
- R10: While gen_en is low or control bit29 (hold) is set, no new word starts. Status bit29 reads 1 and the remaining count in status bits 15:2 stays fixed. A word already in flight completes.
- R11: At most one port is valid at a time. A raised valid is held until ready, unless the channel is disabled.
- R12: Writing the control register with bit31 clear stops the channel at once: busy clears and both valids drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Shared enable; low freezes progress |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_lines | input | NREQ | Peripheral request lines |
| p_valid | output | 1 | Peripheral port request valid |
| p_write | output | 1 | Peripheral request is a write |
| p_addr | output | AW | Peripheral address |
| p_wdata | output | 32 | Peripheral write data |
| p_ready | input | 1 | Peripheral accepts request |
| p_rdata | input | 32 | Peripheral read data, valid with p_ready |
| m_valid | output | 1 | Memory port request valid |
| m_write | output | 1 | Memory request is a write |
| m_addr | output | AW | Memory address |
| m_wdata | output | 32 | Memory write data |
| m_ready | input | 1 | Memory accepts request |
| m_rdata | input | 32 | Memory read data, valid with m_ready |
| irq | output | 1 | End-of-count interrupt pending |

## Verification
The assertions make four assumptions about the inputs:
- Software does not write a pointer or sequence register in the same cycle as a start.
- Software does not change the count field while the channel is busy.
- A responder presents its read data in the cycle in which it raises ready.
- The channel is disabled only by a control write, which is the one case in which the hold-until-ready rule is relaxed.

The stimulus keeps to these rules. Registers are written one per cycle, pointers are programmed before the start, a rewrite while busy keeps the same count, and read data is a combinational function of the address. Ready on each port follows its own irregular pattern, so back-pressure reaches both the read and the write step of a word.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_MPTR = 3'd2;
  localparam logic [2:0] REG_MSEQ = 3'd3;
  localparam logic [2:0] REG_PPTR = 3'd4;
  localparam logic [2:0] REG_PSEQ = 3'd5;

  localparam int B_EN    = 31;
  localparam int B_IE    = 30;
  localparam int B_HOLD  = 29;
  localparam int B_DIR   = 28;
  localparam int B_ONCE  = 27;
  localparam int B_FLOW  = 21;
  localparam int B_SEL   = 16;
  localparam int B_CNT   = 2;
  localparam int B_DBL   = 19;
  localparam int B_WRAP  = 16;
  localparam int MAX_CNT_W = 14;
endpackage

// File: rtl/dma_blk_counter.sv
module dma_blk_counter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] rem,
  output logic          at_last
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     rem_q <= '0;
    else if (load)  rem_q <= load_val;
    else if (step)  rem_q <= (rem_q == '0) ? reload_val : rem_q - 1'b1;
  end

  assign rem     = rem_q;
  assign at_last = (rem_q == '0);

  // R2
  last_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_last && !load) |=> (rem == $past(reload_val)));
endmodule

// File: rtl/dma_wrap_addr.sv
module dma_wrap_addr #(
  parameter int AW    = 32,
  parameter int WLOG0 = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          restart,
  input  logic          step,
  input  logic [AW-1:0] base_in,
  input  logic [2:0]    code,
  output logic [AW-1:0] addr
);
  localparam int IW = WLOG0 + 7;

  logic [AW-1:0] base_q, addr_q;
  logic [IW-1:0] idx_q, last_idx;
  logic          wrap_on;

  always_comb begin
    wrap_on  = (code != 3'd0);
    last_idx = '1;
    for (int i = 1; i < 8; i++)
      if (code == 3'(i)) last_idx = IW'((1 << (WLOG0 + i - 1)) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
      idx_q  <= '0;
    end else if (load || restart) begin
      base_q <= base_in & ~AW'(3);
      addr_q <= base_in & ~AW'(3);
      idx_q  <= '0;
    end else if (step) begin
      if (wrap_on && idx_q == last_idx) begin
        addr_q <= base_q;
        idx_q  <= '0;
      end else begin
        addr_q <= addr_q + AW'(4);
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign addr = addr_q;

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !restart && !wrap_on) |=> (addr == $past(addr) + AW'(4)));
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 14,
  parameter int NREQ  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic [NREQ-1:0] req_lines,
  output logic            p_valid,
  output logic            p_write,
  output logic [AW-1:0]   p_addr,
  output logic [31:0]     p_wdata,
  input  logic            p_ready,
  input  logic [31:0]     p_rdata,
  output logic            m_valid,
  output logic            m_write,
  output logic [AW-1:0]   m_addr,
  output logic [31:0]     m_wdata,
  input  logic            m_ready,
  input  logic [31:0]     m_rdata,
  output logic            irq
);
  localparam int SEL_W = $clog2(NREQ);

  logic [31:0]   ctrl_q, mseq_q, pseq_q, buf_q;
  logic [AW-1:0] mptr_q, pptr_q;
  logic          busy_q, pend_q, pp_q;
  dma_st_e       state_q;

  logic             ie, hold, dir, once, flow, cont, halted;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] cnt, rem;
  logic             at_last;
  logic             ctrl_wr, stat_clr, start, ch_stop, go;
  logic             src_ready, dst_ready, word_done, blk_end, restart;
  logic [31:0]      src_rdata, stat_w;

  assign ie   = ctrl_q[B_IE];
  assign hold = ctrl_q[B_HOLD];
  assign dir  = ctrl_q[B_DIR];
  assign once = ctrl_q[B_ONCE];
  assign flow = ctrl_q[B_FLOW];
  assign sel  = ctrl_q[B_SEL +: SEL_W];
  assign cnt  = ctrl_q[B_CNT +: CNT_W];
  assign cont = mseq_q[B_DBL] && !once;

  assign ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
  assign stat_clr = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[B_IE];
  assign start    = ctrl_wr && cfg_wdata[B_EN] && !busy_q;
  assign ch_stop  = ctrl_wr && !cfg_wdata[B_EN];
  assign halted   = busy_q && (!gen_en || hold);
  assign go       = busy_q && !ch_stop && gen_en && !hold && (!flow || req_lines[sel]);

  assign src_ready = dir ? m_ready : p_ready;
  assign src_rdata = dir ? m_rdata : p_rdata;
  assign dst_ready = dir ? p_ready : m_ready;
  assign word_done = (state_q == ST_WR) && dst_ready;
  assign blk_end   = word_done && at_last;
  assign restart   = blk_end && cont && pp_q;

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mptr_q <= '0;
      mseq_q <= '0;
      pptr_q <= '0;
      pseq_q <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          REG_MPTR: mptr_q <= AW'(cfg_wdata);
          REG_MSEQ: mseq_q <= cfg_wdata;
          REG_PPTR: pptr_q <= AW'(cfg_wdata);
          REG_PSEQ: pseq_q <= cfg_wdata;
          default: ;
        endcase
      end
      if (ctrl_wr)                ctrl_q <= cfg_wdata;
      else if (blk_end && !cont)  ctrl_q[B_EN] <= 1'b0;
    end
  end

  // channel state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      pp_q   <= 1'b0;
    end else begin
      if (start)                  busy_q <= 1'b1;
      else if (ch_stop)           busy_q <= 1'b0;
      else if (blk_end && !cont)  busy_q <= 1'b0;

      if (blk_end && ie)  pend_q <= 1'b1;
      else if (stat_clr)  pend_q <= 1'b0;

      if (start)                  pp_q <= 1'b0;
      else if (blk_end && cont)   pp_q <= ~pp_q;
    end
  end

  // per-word sequencer
  always_ff @(posedge clk) begin
    if (!rst_n || ch_stop || !busy_q) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (go)        state_q <= ST_RD;
        ST_RD:   if (src_ready) state_q <= ST_WR;
        ST_WR:   if (dst_ready) state_q <= ST_IDLE;
        default:                state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                buf_q <= '0;
    else if (state_q == ST_RD && src_ready)    buf_q <= src_rdata;
  end

  dma_blk_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_val(cfg_wdata[B_CNT +: CNT_W]),
    .step(word_done), .reload_val(cnt),
    .rem(rem), .at_last(at_last)
  );

  dma_wrap_addr #(.AW(AW), .WLOG0(5)) u_maddr (
    .clk(clk), .rst_n(rst_n),
    .load(start), .restart(restart), .step(word_done),
    .base_in(mptr_q), .code(mseq_q[B_WRAP +: 3]), .addr(m_addr)
  );

  dma_wrap_addr #(.AW(AW), .WLOG0(0)) u_paddr (
    .clk(clk), .rst_n(rst_n),
    .load(start), .restart(restart), .step(word_done),
    .base_in(pptr_q), .code(pseq_q[B_WRAP +: 3]), .addr(p_addr)
  );

  assign p_valid = ((state_q == ST_RD) && !dir) || ((state_q == ST_WR) && dir);
  assign m_valid = ((state_q == ST_RD) && dir) || ((state_q == ST_WR) && !dir);
  assign p_write = (state_q == ST_WR);
  assign m_write = (state_q == ST_WR);
  assign p_wdata = buf_q;
  assign m_wdata = buf_q;
  assign irq     = pend_q;

  always_comb begin
    stat_w = '0;
    stat_w[31] = busy_q;
    stat_w[30] = pend_q;
    stat_w[29] = halted;
    stat_w[28] = pp_q;
    if (busy_q) stat_w[B_CNT +: CNT_W] = rem;
  end

  always_comb begin
    case (cfg_addr)
      REG_CTRL: cfg_rdata = ctrl_q;
      REG_STAT: cfg_rdata = stat_w;
      REG_MPTR: cfg_rdata = 32'(mptr_q);
      REG_MSEQ: cfg_rdata = mseq_q;
      REG_PPTR: cfg_rdata = 32'(pptr_q);
      REG_PSEQ: cfg_rdata = pseq_q;
      default:  cfg_rdata = '0;
    endcase
  end

  // R11
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_valid && m_valid));

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !p_ready && !ch_stop) |=> (p_valid && $stable(p_addr)));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !p_valid && !m_valid && !cfg_we) |=> (!p_valid && !m_valid && $stable(rem)));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(word_done));

  // R2
  oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !cont) |=> (!busy_q && !p_valid && !m_valid));
endmodule

// File: tb/pp_dma_chan_bench.sv
`timescale 1ns/1ps
module pp_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] req_lines = '0;
  logic        p_valid, p_write, m_valid, m_write, irq;
  logic [31:0] p_addr, p_wdata, m_addr, m_wdata, p_rdata, m_rdata;
  logic        p_ready = 1'b0, m_ready = 1'b0;

  always #2.5 clk = ~clk;

  assign p_rdata = 32'hC0DE0000 ^ p_addr;
  assign m_rdata = 32'h5EED0000 ^ m_addr;

  pp_dma_chan u_pp_dma_chan (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_lines(req_lines),
    .p_valid(p_valid), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_ready(p_ready), .p_rdata(p_rdata),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        side;   // 1 = memory port
    logic        eob;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;

  exp_t expq[$];
  int   checks = 0, errors = 0, cyc = 0, wr_seen = 0;
  logic irq_m = 1'b0, set_f = 1'b0, clr_f = 1'b0, ie_m = 1'b0;
  logic done_f = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic take(input logic side, input logic [31:0] addr, input logic [31:0] data);
    exp_t e;
    wr_seen++;
    if (expq.size() == 0) begin
      chk(1'b0, "R2 unexpected write", addr, 32'h0);
    end else begin
      e = expq.pop_front();
      chk(side == e.side, "R3 write side", 32'(side), 32'(e.side));
      chk(addr == e.addr, "R4/R5 write address", addr, e.addr);
      chk(data == e.data, "R3 write data", data, e.data);
      if (e.eob && ie_m) set_f = 1'b1;
    end
  endtask

  // inputs sampled at the edge that applies them
  always @(posedge clk) clr_f <= cfg_we && (cfg_addr == 3'd1) && cfg_wdata[30];

  // reference model step and port responders
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      irq_m = 1'b0;
      set_f = 1'b0;
    end else begin
      if (set_f) irq_m = 1'b1;
      else if (clr_f) irq_m = 1'b0;
      set_f = 1'b0;
      chk(irq === irq_m, "R6 irq", 32'(irq), 32'(irq_m));
    end
    p_ready = (cyc % 5) != 2;
    m_ready = (cyc % 3) != 1;
    if (p_valid && p_ready && p_write) take(1'b0, p_addr, p_wdata);
    if (m_valid && m_ready && m_write) take(1'b1, m_addr, m_wdata);
    if (cyc > 100000 && !done_f) begin
      done_f = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit ie, input bit hold, input bit dir,
                                       input bit once, input bit flow, input int sel, input int cnt);
    return {en, ie, hold, dir, once, 5'b0, flow, 5'(sel), 14'(cnt), 2'b00};
  endfunction

  function automatic logic [31:0] waddr(input logic [31:0] base, input int k, input int win);
    int off;
    off = (win == 0) ? k : (k % win);
    return (base & ~32'd3) + 32'(4 * off);
  endfunction

  task automatic plan(input bit dir, input int n, input int tot, input logic [31:0] mb, input int mc,
                      input logic [31:0] pb, input int pc);
    int mw, pw;
    exp_t e;
    mw = (mc == 0) ? 0 : (1 << (mc + 4));
    pw = (pc == 0) ? 0 : (1 << (pc - 1));
    for (int k = 0; k < tot; k++) begin
      e.eob = ((k + 1) % n) == 0;
      if (!dir) begin
        e.side = 1'b1;
        e.addr = waddr(mb, k, mw);
        e.data = 32'hC0DE0000 ^ waddr(pb, k, pw);
      end else begin
        e.side = 1'b0;
        e.addr = waddr(pb, k, pw);
        e.data = 32'h5EED0000 ^ waddr(mb, k, mw);
      end
      expq.push_back(e);
    end
  endtask

  task automatic setup(input logic [31:0] mb, input logic [31:0] mseq, input logic [31:0] pb,
                       input logic [31:0] pseq);
    cfg_wr(3'd2, mb);
    cfg_wr(3'd3, mseq);
    cfg_wr(3'd4, pb);
    cfg_wr(3'd5, pseq);
  endtask

  task automatic drain(input string rq);
    int t = 0;
    while (expq.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(expq.size() == 0, rq, 32'(expq.size()), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_irq();
    int t = 0;
    while (!irq && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(irq === 1'b1, "R7 half interrupt", 32'(irq), 32'd1);
  endtask

  initial begin
    logic [31:0] s, s1, s2;
    int w0, w1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_rd(3'd1, s);
    chk(s == 32'd0, "R1 status after reset", s, 32'd0);
    chk(!p_valid && !m_valid, "R1 valids after reset", 32'({p_valid, m_valid}), 32'd0);
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'd0);

    // R2 R3 R6: single-shot, peripheral to memory, 5 words
    ie_m = 1'b1;
    setup(32'h1000, 32'h0, 32'h40, 32'h0);
    plan(1'b0, 5, 5, 32'h1000, 0, 32'h40, 0);
    cfg_wr(3'd0, ctrl(1, 1, 0, 0, 1, 0, 0, 4));
    drain("R2 block of count+1 words");
    cfg_rd(3'd1, s);
    chk(s[31] == 1'b0, "R2 busy clears", 32'(s[31]), 32'd0);
    chk(s[30] == 1'b1, "R6 pending set", 32'(s[30]), 32'd1);
    cfg_rd(3'd0, s);
    chk(s[31] == 1'b0, "R2 enable clears", 32'(s[31]), 32'd0);
    cfg_wr(3'd1, 32'h4000_0000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R6 pending cleared", 32'(irq), 32'd0);

    // R3 R4 R5: memory to peripheral, unaligned pointer, 4-word peripheral window
    ie_m = 1'b0;
    setup(32'h2003, 32'h0, 32'h80, 32'(3 << 16));
    plan(1'b1, 10, 10, 32'h2003, 0, 32'h80, 3);
    cfg_wr(3'd0, ctrl(1, 0, 0, 1, 1, 0, 0, 9));
    drain("R5 peripheral wrap block");
    cfg_rd(3'd1, s);
    chk(s[31:30] == 2'b00, "R6 no pending when disabled", 32'(s[31:30]), 32'd0);

    // R5: 32-word memory window, 40 words
    setup(32'h8000, 32'(1 << 16), 32'h10, 32'h0);
    plan(1'b0, 40, 40, 32'h8000, 1, 32'h10, 0);
    cfg_wr(3'd0, ctrl(1, 0, 0, 0, 1, 0, 0, 39));
    drain("R5 memory wrap block");

    // R9: flow control on line 5
    setup(32'h9000, 32'h0, 32'h20, 32'h0);
    plan(1'b0, 3, 3, 32'h9000, 0, 32'h20, 0);
    req_lines = ~32'h20;
    w0 = wr_seen;
    cfg_wr(3'd0, ctrl(1, 0, 0, 0, 1, 1, 5, 2));
    repeat (40) @(negedge clk);
    chk(wr_seen == w0, "R9 other lines ignored", 32'(wr_seen - w0), 32'd0);
    chk(!p_valid && !m_valid, "R9 no request without line", 32'({p_valid, m_valid}), 32'd0);
    cfg_rd(3'd1, s);
    chk(s[31] && s[15:2] == 14'd2, "R9 waiting with full count", s, 32'h8000_0008);
    req_lines = 32'h20;
    drain("R9 runs once line asserted");
    req_lines = '0;

    // R10: global enable and hold freeze progress
    setup(32'hA000, 32'h0, 32'h30, 32'h0);
    plan(1'b0, 20, 20, 32'hA000, 0, 32'h30, 0);
    w0 = wr_seen;
    cfg_wr(3'd0, ctrl(1, 0, 0, 0, 1, 0, 0, 19));
    while (wr_seen < w0 + 3) @(negedge clk);
    gen_en = 1'b0;
    repeat (10) @(negedge clk);
    cfg_rd(3'd1, s1);
    w1 = wr_seen;
    repeat (30) @(negedge clk);
    cfg_rd(3'd1, s2);
    chk(s1[29] == 1'b1, "R10 halted flag", 32'(s1[29]), 32'd1);
    chk(s1[15:2] == s2[15:2], "R10 count stable", 32'(s2[15:2]), 32'(s1[15:2]));
    chk(wr_seen == w1, "R10 no words while disabled", 32'(wr_seen - w1), 32'd0);
    gen_en = 1'b1;
    cfg_wr(3'd0, ctrl(1, 0, 1, 0, 1, 0, 0, 19));
    repeat (10) @(negedge clk);
    cfg_rd(3'd1, s1);
    w1 = wr_seen;
    repeat (20) @(negedge clk);
    cfg_rd(3'd1, s2);
    chk(s1[29] == 1'b1, "R10 halted under hold", 32'(s1[29]), 32'd1);
    chk(wr_seen == w1 && s1[15:2] == s2[15:2], "R10 hold freezes", 32'(wr_seen - w1), 32'd0);
    cfg_wr(3'd0, ctrl(1, 0, 0, 0, 1, 0, 0, 19));
    drain("R10 completes after resume");

    // R7 R8 R12: continuous ping-pong, 4 words per half
    ie_m = 1'b1;
    setup(32'h4000, 32'(1 << 19), 32'h300, 32'h0);
    plan(1'b0, 4, 8, 32'h4000, 0, 32'h300, 0);
    plan(1'b0, 4, 8, 32'h5000, 0, 32'h300, 0);
    plan(1'b0, 4, 8, 32'h5000, 0, 32'h300, 0);
    w0 = wr_seen;
    cfg_wr(3'd0, ctrl(1, 1, 0, 0, 0, 0, 0, 3));
    for (int h = 1; h <= 4; h++) begin
      wait_irq();
      cfg_rd(3'd1, s);
      chk(s[28] == 1'(h % 2), "R7 ping-pong flag", 32'(s[28]), 32'(h % 2));
      chk(s[31] == 1'b1, "R7 still busy", 32'(s[31]), 32'd1);
      cfg_wr(3'd1, 32'h4000_0000);
      if (h == 1) cfg_wr(3'd2, 32'h5000);   // R8 rewrite mid-buffer
    end
    cfg_wr(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk(!p_valid && !m_valid, "R12 valids drop on disable", 32'({p_valid, m_valid}), 32'd0);
    cfg_rd(3'd1, s);
    chk(s[31] == 1'b0, "R12 busy clears on disable", 32'(s[31]), 32'd0);
    chk(wr_seen - w0 >= 16, "R7 ran across both halves", 32'(wr_seen - w0), 32'd16);
    expq.delete();
    repeat (10) @(negedge clk);
    chk(!p_valid && !m_valid, "R12 stays stopped", 32'({p_valid, m_valid}), 32'd0);

    done_f = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule